// File: doc/BRIEF.md
# Sync output pulse regenerator

This block rebuilds the horizontal and vertical sync outputs of a video capture front end. Each line is marked by a one-cycle line-start strobe from the clock recovery logic, which is outside this block. On every strobe the block opens a horizontal output pulse that lasts a programmed number of pixel clocks. The pulse is driven at a selectable output level. The width of the incoming sync pulse plays no part.

The block also decides which horizontal sync source is in use: a separate sync input or a sync embedded on the green channel. Software can force the choice with an override bit. Otherwise the choice follows two activity flags from a detector, and the select bit settles the case where both sources are active. The block reports the choice on an indicator output.

The vertical output is taken from either the vertical input pin or the sync separator's vertical output, and can be inverted. It has its own override and select bits. Without the override, it follows the horizontal source choice.

Top module: `sync_regen`

## Requirements
- R1: While reset is asserted and just after it, `hs_src_sog` is 0 and `vs_out` is 0. `hs_out` sits at its idle level, which equals `hs_out_neg`.
- R2: A `line_start` pulse sampled with `hs_width` = W (1..255) makes `hs_out` active from the next clock cycle. It stays active for exactly W cycles and then returns to idle.
- R3: When `hs_out_neg` = 0, the active level of `hs_out` is 1 and the idle level is 0. When `hs_out_neg` = 1, the active level is 0 and the idle level is 1.
- R4: A `line_start` sampled while `hs_width` = 0 starts no pulse. `hs_out` stays idle.
- R5: A `line_start` that arrives while a pulse is active restarts the count. The pulse then ends W cycles after the later strobe.
- R6: With `hs_override` = 1, `hs_src_sog` takes the value of `hs_select` one cycle later. In that value, 0 means separate sync and 1 means sync-on-green.
- R7: With `hs_override` = 0, `hs_src_sog` one cycle later points to the source whose activity flag is set. If both flags are set, it takes the value of `hs_select`.
- R8: With `hs_override` = 0 and neither activity flag set, `hs_src_sog` becomes 0 (separate sync) one cycle later.
- R9: With `vs_override` = 1, the vertical source is `vs_pin` when `vs_select` = 0 and `vs_sep` when `vs_select` = 1.
- R10: With `vs_override` = 0, the vertical source is `vs_sep` when the horizontal choice of the same cycle is sync-on-green, and `vs_pin` otherwise.
- R11: `vs_out` is registered and follows one cycle after its inputs. It equals the chosen vertical source when `vs_keep` = 1, and the inverse of that source when `vs_keep` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle line-start strobe from clock recovery |
| hs_sep_seen | input | 1 | Separate horizontal sync is active |
| hs_sog_seen | input | 1 | Sync-on-green is active |
| hs_override | input | 1 | Force horizontal source from hs_select |
| hs_select | input | 1 | Horizontal source: 0 separate, 1 sync-on-green; tie-break |
| hs_width | input | 8 | Output pulse width in pixel clocks |
| hs_out_neg | input | 1 | 0: active-high output pulse, 1: active-low |
| vs_pin | input | 1 | Vertical sync from the input pin |
| vs_sep | input | 1 | Vertical sync from the sync separator |
| vs_override | input | 1 | Force vertical source from vs_select |
| vs_select | input | 1 | Vertical source: 0 pin, 1 separator |
| vs_keep | input | 1 | 0: invert vertical output, 1: pass through |
| hs_out | output | 1 | Regenerated horizontal sync |
| vs_out | output | 1 | Regenerated vertical sync |
| hs_src_sog | output | 1 | Horizontal source in use: 1 sync-on-green |

## Verification
The source indicator and the vertical output are each one register stage behind their inputs. The bench drives those inputs on a falling edge and samples the results on the next falling edge, after exactly one rising edge. `hs_out` turns active on the first falling edge after the rising edge that captured the strobe. The bench therefore counts active falling-edge samples from that point, and the count must equal the programmed width. The polarity bit acts combinationally on the level of `hs_out`, so idle and active levels are compared against the polarity bit in force at the sample time.

// File: rtl/sync_regen_pkg.sv
package sync_regen_pkg;
  typedef enum logic {
    SRC_SEPARATE = 1'b0,
    SRC_ON_GREEN = 1'b1
  } hs_src_e;

  function automatic hs_src_e pick_hs_source(
    input logic force_en,
    input logic sel,
    input logic sep_seen,
    input logic sog_seen
  );
    hs_src_e pick;
    if (force_en)                  pick = hs_src_e'(sel);
    else if (sep_seen && sog_seen) pick = hs_src_e'(sel);
    else if (sog_seen)             pick = SRC_ON_GREEN;
    else                           pick = SRC_SEPARATE;
    return pick;
  endfunction
endpackage

// File: rtl/sync_regen_src_pick.sv
module sync_regen_src_pick
  import sync_regen_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    force_en,
  input  logic    sel,
  input  logic    sep_seen,
  input  logic    sog_seen,
  output hs_src_e pick_now,
  output hs_src_e pick_q
);
  hs_src_e pick_d;

  always_comb begin
    pick_d   = pick_hs_source(force_en, sel, sep_seen, sog_seen);
    pick_now = pick_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pick_q <= SRC_SEPARATE;
    else        pick_q <= pick_d;
  end
endmodule

// File: rtl/sync_regen_pulse.sv
module sync_regen_pulse #(
  parameter int WIDTH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH_W-1:0] width,
  output logic               active
);
  localparam logic [WIDTH_W-1:0] CNT_ZERO = '0;

  logic [WIDTH_W-1:0] cnt_q;
  logic [WIDTH_W-1:0] cnt_d;
  logic               load;
  logic               busy;
  logic               cnt_en;

  always_comb begin
    load   = start && (width != CNT_ZERO);
    busy   = (cnt_q != CNT_ZERO);
    cnt_en = load || busy;
    cnt_d  = cnt_q;
    if (load)      cnt_d = width;
    else if (busy) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_ZERO;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = busy;
endmodule

// File: rtl/sync_regen_vs_path.sv
module sync_regen_vs_path (
  input  logic clk,
  input  logic rst_n,
  input  logic force_en,
  input  logic sel,
  input  logic follow_sep,
  input  logic pin_in,
  input  logic sep_in,
  input  logic keep,
  output logic vs_q
);
  logic use_sep;
  logic raw;
  logic vs_d;

  always_comb begin
    use_sep = force_en ? sel : follow_sep;
    raw     = use_sep ? sep_in : pin_in;
    vs_d    = keep ? raw : ~raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vs_q <= 1'b0;
    else        vs_q <= vs_d;
  end
endmodule

// File: rtl/sync_regen.sv
module sync_regen
  import sync_regen_pkg::*;
#(
  parameter int WIDTH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_start,
  input  logic               hs_sep_seen,
  input  logic               hs_sog_seen,
  input  logic               hs_override,
  input  logic               hs_select,
  input  logic [WIDTH_W-1:0] hs_width,
  input  logic               hs_out_neg,
  input  logic               vs_pin,
  input  logic               vs_sep,
  input  logic               vs_override,
  input  logic               vs_select,
  input  logic               vs_keep,
  output logic               hs_out,
  output logic               vs_out,
  output logic               hs_src_sog
);
  hs_src_e pick_now;
  hs_src_e pick_q;
  logic    pulse_on;

  sync_regen_src_pick u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .force_en (hs_override),
    .sel      (hs_select),
    .sep_seen (hs_sep_seen),
    .sog_seen (hs_sog_seen),
    .pick_now (pick_now),
    .pick_q   (pick_q)
  );

  sync_regen_pulse #(.WIDTH_W(WIDTH_W)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (line_start),
    .width  (hs_width),
    .active (pulse_on)
  );

  sync_regen_vs_path u_vs (
    .clk        (clk),
    .rst_n      (rst_n),
    .force_en   (vs_override),
    .sel        (vs_select),
    .follow_sep (pick_now == SRC_ON_GREEN),
    .pin_in     (vs_pin),
    .sep_in     (vs_sep),
    .keep       (vs_keep),
    .vs_q       (vs_out)
  );

  assign hs_out     = pulse_on ^ hs_out_neg;
  assign hs_src_sog = (pick_q == SRC_ON_GREEN);
endmodule

// File: rtl/sync_regen_chk.sv
module sync_regen_chk #(
  parameter int WIDTH_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               line_start,
  input logic               hs_sep_seen,
  input logic               hs_sog_seen,
  input logic               hs_override,
  input logic               hs_select,
  input logic [WIDTH_W-1:0] hs_width,
  input logic               hs_out_neg,
  input logic               vs_pin,
  input logic               vs_sep,
  input logic               vs_override,
  input logic               vs_select,
  input logic               vs_keep,
  input logic               hs_out,
  input logic               vs_out,
  input logic               hs_src_sog
);
  always_comb begin
    if (!rst_n) begin
      assert_reset_state_R1: assert (hs_src_sog == 1'b0 && vs_out == 1'b0);
    end
  end

  assert_pulse_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && hs_width != '0) |=> (hs_out != hs_out_neg));

  assert_zero_width_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_out == hs_out_neg && !(line_start && hs_width != '0)) |=> (hs_out == hs_out_neg));

  assert_override_pick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hs_override |=> (hs_src_sog == $past(hs_select)));

  assert_auto_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_override && (hs_sep_seen != hs_sog_seen)) |=> (hs_src_sog == $past(hs_sog_seen)));

  assert_fallback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_override && !hs_sep_seen && !hs_sog_seen) |=> !hs_src_sog);

  assert_vs_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vs_override |=> (vs_out == (($past(vs_select) ? $past(vs_sep) : $past(vs_pin)) ^ !$past(vs_keep))));
endmodule

bind sync_regen sync_regen_chk #(.WIDTH_W(WIDTH_W)) u_chk (.*);

// File: tb/sync_regen_tb.sv
module sync_regen_tb;
  localparam int CLK_P   = 10;
  localparam int WIDTH_W = 8;
  localparam int N_VEC   = 10;
  localparam int WD_MAX  = 20000;

  // bits: [10]hs_ov [9]hs_sel [8]sep_seen [7]sog_seen [6]vs_ov [5]vs_sel
  //       [4]vs_pin [3]vs_sep [2]vs_keep [1]exp_src [0]exp_vs
  localparam logic [10:0] VEC [N_VEC] = '{
    11'b1_0_0_1_1_0_1_0_1_0_1,
    11'b1_1_1_0_1_1_0_1_0_1_0,
    11'b0_1_1_0_0_0_1_0_1_0_1,
    11'b0_0_0_1_0_0_0_1_1_1_1,
    11'b0_1_1_1_0_0_1_0_0_1_1,
    11'b0_0_1_1_0_0_0_1_0_0_1,
    11'b0_1_0_0_0_1_1_0_1_0_1,
    11'b0_0_0_0_1_1_1_0_1_0_0,
    11'b1_0_0_0_1_0_0_0_0_0_1,
    11'b1_1_0_0_0_0_0_1_1_1_1
  };

  logic clk = 1'b0;
  logic rst_n;
  logic line_start, hs_sep_seen, hs_sog_seen, hs_override, hs_select;
  logic [WIDTH_W-1:0] hs_width;
  logic hs_out_neg, vs_pin, vs_sep, vs_override, vs_select, vs_keep;
  logic hs_out, vs_out, hs_src_sog;

  int n_checks = 0;
  int n_errors = 0;
  int cycles   = 0;

  always #(CLK_P/2) clk = ~clk;

  sync_regen #(.WIDTH_W(WIDTH_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .hs_sep_seen(hs_sep_seen), .hs_sog_seen(hs_sog_seen),
    .hs_override(hs_override), .hs_select(hs_select),
    .hs_width(hs_width), .hs_out_neg(hs_out_neg),
    .vs_pin(vs_pin), .vs_sep(vs_sep), .vs_override(vs_override),
    .vs_select(vs_select), .vs_keep(vs_keep),
    .hs_out(hs_out), .vs_out(vs_out), .hs_src_sog(hs_src_sog)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_MAX) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WD_MAX);
      report();
    end
  end

  // strobe once and count active samples until idle
  task automatic pulse_len(input int w, input logic neg, output int len);
    @(negedge clk);
    hs_width = w[WIDTH_W-1:0];
    hs_out_neg = neg;
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    len = 0;
    while (hs_out != neg && len < 300) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    int len;
    rst_n = 1'b0; line_start = 1'b0; hs_sep_seen = 1'b0; hs_sog_seen = 1'b0;
    hs_override = 1'b0; hs_select = 1'b0; hs_width = 8'd0; hs_out_neg = 1'b0;
    vs_pin = 1'b1; vs_sep = 1'b1; vs_override = 1'b0; vs_select = 1'b0; vs_keep = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 hs_out idle in reset", hs_out, 0);
    check("R1 vs_out in reset", vs_out, 0);
    check("R1 hs_src_sog in reset", hs_src_sog, 0);
    rst_n = 1'b1;

    // table-driven source selection and vertical path
    for (int i = 0; i < N_VEC; i++) begin
      @(negedge clk);
      {hs_override, hs_select, hs_sep_seen, hs_sog_seen,
       vs_override, vs_select, vs_pin, vs_sep, vs_keep} = VEC[i][10:2];
      @(negedge clk);
      check($sformatf("R6/R7/R8 vec%0d hs_src_sog", i), hs_src_sog, VEC[i][1]);
      check($sformatf("R9/R10/R11 vec%0d vs_out", i), vs_out, VEC[i][0]);
    end

    // R2 and R3 pulse length and level
    pulse_len(5, 1'b0, len);
    check("R2 width 5 active-high length", len, 5);
    check("R3 idle level with polarity 0", hs_out, 0);
    pulse_len(1, 1'b1, len);
    check("R2 width 1 active-low length", len, 1);
    check("R3 idle level with polarity 1", hs_out, 1);
    pulse_len(255, 1'b0, len);
    check("R2 width 255 length", len, 255);

    // R3 active level with polarity 1
    @(negedge clk);
    hs_width = 8'd4; hs_out_neg = 1'b1; line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    check("R3 active level with polarity 1", hs_out, 0);
    repeat (5) @(negedge clk);

    // R4 zero width gives no pulse
    hs_out_neg = 1'b0;
    pulse_len(0, 1'b0, len);
    check("R4 width 0 no pulse", len, 0);
    repeat (3) @(negedge clk);
    check("R4 still idle", hs_out, 0);

    // R5 restart mid-pulse: 3 cycles, then 6 more from the second strobe
    @(negedge clk);
    hs_width = 8'd6; line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    len = 0;
    while (hs_out != hs_out_neg && len < 300) begin
      len++;
      line_start = (len == 3);
      @(negedge clk);
    end
    line_start = 1'b0;
    check("R5 restarted pulse total length", len, 9);

    report();
  end
endmodule